// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one timer channel of a programmable interval counter. It counts ticks of a count-enable strobe against an initial count of up to 65536. It drives an output level whose waveform depends on one of six counting modes: terminal flag, retriggerable one-shot, rate pulse, square wave, software strobe and hardware strobe. A gate input can suspend counting in some modes and restart the count in others.

A host front-end writes a mode and a 16-bit initial count in one cycle. The channel provides its live readable count value and its output level, so that a separate register front-end can latch them. Bus decoding, byte sequencing and decimal counting are handled outside the block.

The channel keeps an elapsed-tick counter from the last restart. It derives both the output level and the readable count from that counter, the loaded count and the mode.

Top module: `interval_counter_ch`

## Requirements
- R1: A loaded initial count of 0 acts as 65536. After such a load in mode 0, the readable count is 0x0000 and the output goes high only on the 65536th counted tick.
- R2: Mode code 0 (terminal flag) holds the output low after a load. The output rises on the counted tick where the elapsed ticks equal the count, and stays high until the next load. The readable count is the count minus the elapsed ticks, modulo 2^16, so it wraps past zero to 0xFFFF.
- R3: Mode code 1 (one-shot) holds the output high from a load or retrigger until the elapsed ticks equal the count. It then holds the output low.
- R4: Mode code 2 (rate) holds the output low, except for one tick interval each time the elapsed ticks reach a nonzero multiple of the count. The readable count runs count, count-1, ..., 1 and then reloads.
- R5: Mode code 3 (square wave) has a period of the count. The output is high while the elapsed ticks within a period are below (count+1)/2. The readable count is the count minus twice the in-period ticks, modulo the count, so it steps down by two per tick.
- R6: Mode codes 4 and 5 (strobes) raise the output for exactly one tick interval, when the elapsed ticks equal the count. They raise it never again until a restart.
- R7: A rising edge on the gate restarts the count in modes 1, 2, 3 and 5. In modes 0 and 4 a gate rising edge does not restart the count.
- R8: In modes 0 and 4, ticks are ignored while the gate is low. Neither the readable count nor the output changes.
- R9: A load or retrigger clears the elapsed ticks at once, so the readable count equals the loaded value. The first enabled tick after it is absorbed and not counted.
- R10: After reset the channel is in mode 3 with count 65536. The readable count is 0x0000 and the output is high. The sampled gate reference resets high for channel index 0 and 1 and low for channel index 2.
- R11: Mode codes 6 and 7 are stored as and behave exactly as modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count-enable strobe, one count per high cycle |
| gate_i | input | 1 | Gate level, sampled every cycle |
| load_i | input | 1 | Load mode and initial count this cycle |
| load_mode_i | input | 3 | Mode code to load |
| load_count_i | input | 16 | Initial count to load, 0 means 65536 |
| count_o | output | 16 | Live readable count value |
| out_o | output | 1 | Channel output level |

## Verification
The properties take the gate and tick inputs to be synchronous to the clock and free of glitches. They also expect a load to carry a defined mode and count. The strobe property holds only because a load is excluded in the cycle that is checked. The bench drives every input a short delay after a rising edge, holds it for a whole cycle, and keeps the tick low while it makes gate edges. As a result, each retrigger and each absorbed tick occurs in a known cycle.

// File: rtl/ictr_pkg.sv
package ictr_pkg;

  typedef enum logic [2:0] {
    M_TERM     = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } ictr_mode_e;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_HIT   = 2'd1,
    ST_DONE  = 2'd2
  } ictr_stage_e;

  // codes 6 and 7 fold onto the periodic modes (R11)
  function automatic ictr_mode_e norm_mode(input logic [2:0] raw);
    case (raw)
      3'd6:    return M_RATE;
      3'd7:    return M_SQUARE;
      default: return ictr_mode_e'(raw);
    endcase
  endfunction

  function automatic logic retrig_mode(input ictr_mode_e m);
    return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HWSTROBE);
  endfunction

  function automatic logic gated_mode(input ictr_mode_e m);
    return (m == M_TERM) || (m == M_SWSTROBE);
  endfunction

  function automatic logic periodic_mode(input ictr_mode_e m);
    return (m == M_RATE) || (m == M_SQUARE);
  endfunction

endpackage

// File: rtl/ictr_gate_edge.sv
module ictr_gate_edge #(
  parameter bit GATE_RST = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  output logic rise_o
);

  logic gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= GATE_RST;
    else        gate_q <= gate_i;
  end

  assign rise_o = gate_i & ~gate_q;

endmodule

// File: rtl/ictr_phase.sv
module ictr_phase
  import ictr_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int W1 = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              gate_i,
  input  ictr_mode_e        mode_i,
  input  logic [W1-1:0]     nfull_i,
  input  logic              restart_i,
  output logic [CNT_W-1:0]  el_o,
  output ictr_stage_e       stage_o,
  output logic              started_o,
  output logic              step_o
);

  logic              pend_q;
  logic              enabled;
  logic [W1-1:0]     el_inc;
  logic              at_end;
  logic [CNT_W-1:0]  el_next;

  assign enabled = tick_i & (gate_i | ~gated_mode(mode_i));
  assign step_o  = enabled & ~pend_q & ~restart_i;
  assign el_inc  = {1'b0, el_o} + W1'(1);
  assign at_end  = (el_inc == nfull_i);
  assign el_next = (periodic_mode(mode_i) && at_end) ? '0 : el_inc[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      el_o      <= '0;
      stage_o   <= ST_ARMED;
      started_o <= 1'b0;
      pend_q    <= 1'b0;
    end else if (restart_i) begin
      el_o      <= '0;
      stage_o   <= ST_ARMED;
      started_o <= 1'b0;
      pend_q    <= 1'b1;
    end else if (enabled) begin
      if (pend_q) begin
        pend_q <= 1'b0;
      end else begin
        el_o      <= el_next;
        started_o <= 1'b1;
        case (stage_o)
          ST_ARMED: if (at_end) stage_o <= ST_HIT;
          ST_HIT:   stage_o <= ST_DONE;
          default:  stage_o <= ST_DONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/ictr_decode.sv
module ictr_decode
  import ictr_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int W1 = CNT_W + 1
) (
  input  ictr_mode_e        mode_i,
  input  logic [CNT_W-1:0]  nval_i,
  input  logic [W1-1:0]     nfull_i,
  input  logic [CNT_W-1:0]  el_i,
  input  ictr_stage_e       stage_i,
  input  logic              started_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              out_o
);

  function automatic logic [CNT_W-1:0] rd_value(
    input ictr_mode_e m, input logic [CNT_W-1:0] nv,
    input logic [W1-1:0] nf, input logic [CNT_W-1:0] el);
    logic [W1-1:0] twice;
    logic [W1-1:0] diff;
    if (m == M_SQUARE) begin
      twice = {el, 1'b0};
      if (twice >= nf) twice = twice - nf;
      diff = nf - twice;
      return diff[CNT_W-1:0];
    end
    return nv - el;
  endfunction

  function automatic logic out_level(
    input ictr_mode_e m, input logic [W1-1:0] nf,
    input logic [CNT_W-1:0] el, input ictr_stage_e st, input logic started);
    logic [W1-1:0] half;
    half = (nf + W1'(1)) >> 1;
    case (m)
      M_TERM:     return st != ST_ARMED;
      M_ONESHOT:  return st == ST_ARMED;
      M_RATE:     return started && (el == '0);
      M_SQUARE:   return {1'b0, el} < half;
      default:    return st == ST_HIT;
    endcase
  endfunction

  assign count_o = rd_value(mode_i, nval_i, nfull_i, el_i);
  assign out_o   = out_level(mode_i, nfull_i, el_i, stage_i, started_i);

endmodule

// File: rtl/interval_counter_ch.sv
module interval_counter_ch
  import ictr_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int CHAN_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              gate_i,
  input  logic              load_i,
  input  logic [2:0]        load_mode_i,
  input  logic [CNT_W-1:0]  load_count_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              out_o
);

  localparam int W1       = CNT_W + 1;
  localparam bit GATE_RST = (CHAN_IDX != 2);

  ictr_mode_e        mode_q;
  logic [CNT_W-1:0]  nval_q;
  logic [W1-1:0]     nfull;
  logic              gate_rise;
  logic              restart_w;
  logic              step_w;
  logic [CNT_W-1:0]  el_w;
  ictr_stage_e       stage_w;
  logic              started_w;

  // zero count stands for the full 2^CNT_W range (R1)
  assign nfull     = (nval_q == '0) ? (W1'(1) << CNT_W) : {1'b0, nval_q};
  assign restart_w = load_i | (gate_rise & retrig_mode(mode_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_SQUARE;
      nval_q <= '0;
    end else if (load_i) begin
      mode_q <= norm_mode(load_mode_i);
      nval_q <= load_count_i;
    end
  end

  ictr_gate_edge #(.GATE_RST(GATE_RST)) u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .gate_i (gate_i),
    .rise_o (gate_rise)
  );

  ictr_phase #(.CNT_W(CNT_W)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .gate_i    (gate_i),
    .mode_i    (mode_q),
    .nfull_i   (nfull),
    .restart_i (restart_w),
    .el_o      (el_w),
    .stage_o   (stage_w),
    .started_o (started_w),
    .step_o    (step_w)
  );

  ictr_decode #(.CNT_W(CNT_W)) u_decode (
    .mode_i    (mode_q),
    .nval_i    (nval_q),
    .nfull_i   (nfull),
    .el_i      (el_w),
    .stage_i   (stage_w),
    .started_i (started_w),
    .count_o   (count_o),
    .out_o     (out_o)
  );

endmodule

// File: rtl/ictr_chk.sv
module ictr_chk
  import ictr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic [2:0]        load_mode_i,
  input logic [CNT_W-1:0]  load_count_i,
  input logic              gate_i,
  input logic [CNT_W-1:0]  count_o,
  input logic              out_o,
  input ictr_mode_e        mode_q,
  input logic              step_w
);

  a_r1_zero_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && load_count_i == '0 && load_mode_i == 3'd0) |=> (!out_o && count_o == '0));

  a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_TERM && out_o && !load_i) |=> out_o);

  a_r6_strobe_once: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == M_SWSTROBE || mode_q == M_HWSTROBE) && out_o && step_w && !load_i) |=> !out_o);

  a_r8_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == M_TERM || mode_q == M_SWSTROBE) && !gate_i && !load_i)
      |=> ($stable(count_o) && $stable(out_o)));

  a_r9_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (count_o == $past(load_count_i)));

endmodule

bind interval_counter_ch ictr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .load_i       (load_i),
  .load_mode_i  (load_mode_i),
  .load_count_i (load_count_i),
  .gate_i       (gate_i),
  .count_o      (count_o),
  .out_o        (out_o),
  .mode_q       (mode_q),
  .step_w       (step_w)
);

// File: tb/interval_counter_ch_test.sv
module interval_counter_ch_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        gate_i = 1'b1;
  logic        load_i = 1'b0;
  logic [2:0]  load_mode_i = 3'd0;
  logic [15:0] load_count_i = 16'd0;
  logic [15:0] count_o;
  logic        out_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  interval_counter_ch uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .gate_i       (gate_i),
    .load_i       (load_i),
    .load_mode_i  (load_mode_i),
    .load_count_i (load_count_i),
    .count_o      (count_o),
    .out_o        (out_o)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic eo, input logic [15:0] ec);
    n_chk++;
    if (out_o !== eo || count_o !== ec) begin
      n_fail++;
      $display("FAIL %s: out=%0b count=%04h expected out=%0b count=%04h",
               tag, out_o, count_o, eo, ec);
    end
  endtask

  task automatic do_load(input logic [2:0] m, input logic [15:0] c);
    load_i = 1'b1; load_mode_i = m; load_count_i = c;
    cyc();
    load_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_i = 1'b1;
    repeat (n) cyc();
    tick_i = 1'b0;
  endtask

  task automatic gate_pulse();
    gate_i = 1'b0; cyc();
    gate_i = 1'b1; cyc();
  endtask

  task automatic t_reset();
    chk("R10 reset mode3 count 65536", 1'b1, 16'h0000);
  endtask

  task automatic t_mode0();
    do_load(3'd0, 16'd5);
    chk("R2 after load", 1'b0, 16'd5);
    ticks(1);
    chk("R9 first tick absorbed", 1'b0, 16'd5);
    ticks(4);
    chk("R2 before terminal", 1'b0, 16'd1);
    ticks(1);
    chk("R2 terminal reached", 1'b1, 16'd0);
    ticks(1);
    chk("R2 wrap past zero", 1'b1, 16'hFFFF);
  endtask

  task automatic t_gate_hold();
    do_load(3'd0, 16'd3);
    ticks(1);
    gate_i = 1'b0; cyc();
    ticks(5);
    chk("R8 mode0 gate low holds", 1'b0, 16'd3);
    gate_i = 1'b1; cyc();
    ticks(3);
    chk("R7 mode0 gate edge no restart", 1'b1, 16'd0);
    do_load(3'd4, 16'd2);
    ticks(1);
    gate_i = 1'b0; cyc();
    ticks(3);
    chk("R8 mode4 gate low holds", 1'b0, 16'd2);
    gate_i = 1'b1; cyc();
    ticks(2);
    chk("R6 mode4 strobe", 1'b1, 16'd0);
    ticks(1);
    chk("R6 mode4 strobe ends", 1'b0, 16'hFFFF);
    ticks(4);
    chk("R6 mode4 no second strobe", 1'b0, 16'hFFFB);
  endtask

  task automatic t_mode1();
    do_load(3'd1, 16'd3);
    chk("R3 high after load", 1'b1, 16'd3);
    ticks(3);
    chk("R3 high while counting", 1'b1, 16'd1);
    ticks(1);
    chk("R3 low at count", 1'b0, 16'd0);
    ticks(2);
    chk("R3 stays low", 1'b0, 16'hFFFE);
    gate_pulse();
    chk("R7 mode1 retrigger", 1'b1, 16'd3);
    ticks(4);
    chk("R7 mode1 after retrigger", 1'b0, 16'd0);
  endtask

  task automatic t_rate(input logic [2:0] m, input string tag);
    do_load(m, 16'd4);
    chk(tag, 1'b0, 16'd4);
    ticks(1);
    for (int k = 1; k <= 9; k++) begin
      int el;
      ticks(1);
      el = k % 4;
      chk(tag, (el == 0), 16'(4 - el));
    end
  endtask

  task automatic t_square(input logic [2:0] m, input int n, input string tag);
    do_load(m, 16'(n));
    chk(tag, 1'b1, 16'(n));
    ticks(1);
    for (int k = 1; k <= 2 * n; k++) begin
      int el;
      int tw;
      ticks(1);
      el = k % n;
      tw = 2 * el;
      if (tw >= n) tw = tw - n;
      chk(tag, (el < (n + 1) / 2), 16'(n - tw));
    end
  endtask

  task automatic t_square_retrig();
    do_load(3'd3, 16'd5);
    ticks(3);
    chk("R5 mid period", 1'b1, 16'd1);
    gate_pulse();
    chk("R7 mode3 retrigger", 1'b1, 16'd5);
    ticks(2);
    chk("R7 mode3 counting again", 1'b1, 16'd3);
  endtask

  task automatic t_mode5();
    do_load(3'd5, 16'd3);
    chk("R6 mode5 low after load", 1'b0, 16'd3);
    ticks(4);
    chk("R6 mode5 strobe", 1'b1, 16'd0);
    ticks(1);
    chk("R6 mode5 strobe ends", 1'b0, 16'hFFFF);
    gate_pulse();
    chk("R7 mode5 retrigger", 1'b0, 16'd3);
    ticks(4);
    chk("R7 mode5 strobe again", 1'b1, 16'd0);
  endtask

  task automatic t_zero();
    do_load(3'd0, 16'd0);
    chk("R1 zero load reads 0", 1'b0, 16'h0000);
    ticks(1);
    ticks(65535);
    chk("R1 one tick before 65536", 1'b0, 16'd1);
    ticks(1);
    chk("R1 terminal at 65536", 1'b1, 16'h0000);
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_mode0();
    t_gate_hold();
    t_mode1();
    t_rate(3'd2, "R4 rate");
    t_rate(3'd6, "R11 code6 as rate");
    t_square(3'd3, 5, "R5 square odd");
    t_square(3'd3, 4, "R5 square even");
    t_square(3'd7, 5, "R11 code7 as square");
    t_square_retrig();
    t_mode5();
    t_zero();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule